// File: doc/BRIEF.md
# Associative Register Rename Map

This block holds the register renaming state of an out-of-order core as a content-addressable table with one entry per physical register. Each entry records which architectural register it belongs to and carries two flags: one marking it as the current (speculative) mapping and one marking it as the committed mapping for that architectural register. A source operand is translated by searching every entry for the architectural number with the current flag set and encoding the position of the hit into a physical register index.

Renaming a destination takes the lowest-numbered free entry, tags it with the architectural number, makes it current and removes the current flag from the entry that held that register before. Retiring an instruction moves the committed flag of that architectural register onto the instruction's entry. An entry with neither flag set is free. Any recovery, for a mispredicted branch or an exception, overwrites the whole current column with the committed column in one clock, so the map returns to the retired state at once.

Top module: `camRenameMap`

## Requirements
- R1: After reset, entries 0 to 31 are current and committed for architectural registers 0 to 31 (entry i for register i), and entries 32 to 63 are free; a lookup of register i returns i with the hit flag set.
- R2: The lookup is combinational: `lookupPhys` is the index of the entry whose tag equals `lookupArch` and whose current flag is set, and `lookupHit` is 1.
- R3: With `renValid` high and a free entry present, `renPhys` shows the lowest-numbered free entry in the same cycle; after the clock edge a lookup of `renArch` returns that entry.
- R4: A rename of a register leaves the lookups of every other architectural register unchanged, and the entry that lost the current flag, if committed, is not handed out again.
- R5: With `commitValid` high, entry `commitPhys` gains the committed flag and the previously committed entry of the same architectural register loses it; if that old entry is not current it becomes free and is picked by a later rename under the lowest-index rule.
- R6: With `flush` high, after the edge every lookup returns the committed mapping, and entries that were renamed but not committed become free.
- R7: When no entry is free and `renValid` is high, `renStall` is 1 and neither flag column changes; lookups return what they returned before.
- R8: A rename requested in the same cycle as a flush is dropped; its register keeps the committed mapping.
- R9: A commit in the same cycle as a flush takes effect, and the restored current column includes that commit.
- R10: An entry being committed in a cycle is never chosen by a rename in that same cycle, even when both of its flags are clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| lookupArch | input | 5 | Architectural register to translate |
| lookupPhys | output | 6 | Physical register currently mapped to `lookupArch` |
| lookupHit | output | 1 | A current entry matched `lookupArch` |
| renValid | input | 1 | Request to rename a destination |
| renArch | input | 5 | Architectural destination register |
| renPhys | output | 6 | Entry allocated to the destination |
| renStall | output | 1 | Rename requested with no free entry |
| commitValid | input | 1 | Retire the instruction owning `commitPhys` |
| commitPhys | input | 6 | Entry of the retiring instruction |
| flush | input | 1 | Restore current mappings from committed ones |

## Verification
Renames are driven on fresh registers, on a register renamed twice before retirement, and on every register until the table fills, which separates the lowest-index pick, the release of superseded uncommitted entries and the stall path. Commits are issued alone, together with a rename and together with a flush, so a commit that frees the old entry, the exclusion of the entry being retired, and the ordering between commit and restore each give a different expected index. Flushes after speculative renames show whether uncommitted entries return to the free pool and whether a rename on the flush cycle is dropped.

// File: rtl/camRenamePkg.sv
package camRenamePkg;
  // Strobes from the control to the datapath, one per state update.
  typedef struct packed {
    logic renWrite;
    logic commitWrite;
    logic flushCopy;
  } camStrobes_t;
endpackage

// File: rtl/camRenameCtrl.sv
module camRenameCtrl
  import camRenamePkg::*;
(
  input  logic        renValid,
  input  logic        commitValid,
  input  logic        flush,
  input  logic        anyFree,
  output camStrobes_t strobes,
  output logic        renStall
);
  always_comb begin
    strobes.flushCopy   = flush;
    strobes.commitWrite = commitValid;
    // A recovery cycle discards a rename that arrives with it.
    strobes.renWrite    = renValid && anyFree && !flush;
    renStall            = renValid && !anyFree;
  end
endmodule

// File: rtl/camRenameData.sv
module camRenameData
  import camRenamePkg::*;
#(
  parameter int NUM_ENTRIES = 64,
  parameter int ARCH_BITS   = 5,
  parameter int PHYS_BITS   = $clog2(NUM_ENTRIES)
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  camStrobes_t            strobes,
  input  logic [ARCH_BITS-1:0]   lookupArch,
  output logic [PHYS_BITS-1:0]   lookupPhys,
  output logic                   lookupHit,
  input  logic [ARCH_BITS-1:0]   renArch,
  input  logic [PHYS_BITS-1:0]   commitPhys,
  output logic [PHYS_BITS-1:0]   renPhys,
  output logic                   anyFree,
  output logic [NUM_ENTRIES-1:0] curVec,
  output logic [NUM_ENTRIES-1:0] comVec
);
  localparam int NUM_ARCH = 1 << ARCH_BITS;

  logic [ARCH_BITS-1:0]   archTag [NUM_ENTRIES];
  logic [NUM_ENTRIES-1:0] curValid, comValid;
  logic [NUM_ENTRIES-1:0] lookMatch, renMatch, retireMatch;
  logic [NUM_ENTRIES-1:0] commitHot, freeVec, allocHot, nextCom;
  logic [ARCH_BITS-1:0]   retireArch;

  assign retireArch = archTag[commitPhys];

  // One comparator set per entry.
  for (genvar e = 0; e < NUM_ENTRIES; e++) begin : gEntry
    assign lookMatch[e]   = curValid[e] && (archTag[e] == lookupArch);
    assign renMatch[e]    = curValid[e] && (archTag[e] == renArch);
    assign retireMatch[e] = comValid[e] && (archTag[e] == retireArch);
    assign commitHot[e]   = strobes.commitWrite && (PHYS_BITS'(e) == commitPhys);
    assign freeVec[e]     = !curValid[e] && !comValid[e] && !commitHot[e];
  end

  // Encoder for the single current match.
  always_comb begin
    lookupPhys = '0;
    for (int e = 0; e < NUM_ENTRIES; e++)
      if (lookMatch[e]) lookupPhys = lookupPhys | PHYS_BITS'(e);
    lookupHit = |lookMatch;
  end

  // Lowest index wins: scan downward so the last assignment is the lowest.
  always_comb begin
    renPhys = '0;
    for (int e = NUM_ENTRIES - 1; e >= 0; e--)
      if (freeVec[e]) renPhys = PHYS_BITS'(e);
    anyFree  = |freeVec;
    allocHot = '0;
    allocHot[renPhys] = anyFree;
  end

  always_comb begin
    nextCom = comValid;
    if (strobes.commitWrite)
      nextCom = (comValid & ~(retireMatch & ~commitHot)) | commitHot;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int e = 0; e < NUM_ENTRIES; e++) begin
        archTag[e]  <= (e < NUM_ARCH) ? ARCH_BITS'(e) : '0;
        curValid[e] <= (e < NUM_ARCH);
        comValid[e] <= (e < NUM_ARCH);
      end
    end else begin
      comValid <= nextCom;
      if (strobes.flushCopy) begin
        curValid <= nextCom;
      end else if (strobes.renWrite) begin
        curValid         <= (curValid & ~renMatch) | allocHot;
        archTag[renPhys] <= renArch;
      end
    end
  end

  assign curVec = curValid;
  assign comVec = comValid;
endmodule

// File: rtl/camRenameMap.sv
module camRenameMap
  import camRenamePkg::*;
#(
  parameter int NUM_ENTRIES = 64,
  parameter int ARCH_BITS   = 5,
  localparam int PHYS_BITS  = $clog2(NUM_ENTRIES)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [ARCH_BITS-1:0] lookupArch,
  output logic [PHYS_BITS-1:0] lookupPhys,
  output logic                 lookupHit,
  input  logic                 renValid,
  input  logic [ARCH_BITS-1:0] renArch,
  output logic [PHYS_BITS-1:0] renPhys,
  output logic                 renStall,
  input  logic                 commitValid,
  input  logic [PHYS_BITS-1:0] commitPhys,
  input  logic                 flush
);
  camStrobes_t            strobes;
  logic                   anyFree;
  logic [NUM_ENTRIES-1:0] curVec, comVec;

  camRenameCtrl uCtrl (
    .renValid(renValid), .commitValid(commitValid), .flush(flush),
    .anyFree(anyFree), .strobes(strobes), .renStall(renStall)
  );

  camRenameData #(
    .NUM_ENTRIES(NUM_ENTRIES), .ARCH_BITS(ARCH_BITS), .PHYS_BITS(PHYS_BITS)
  ) uData (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .lookupArch(lookupArch), .lookupPhys(lookupPhys), .lookupHit(lookupHit),
    .renArch(renArch), .commitPhys(commitPhys),
    .renPhys(renPhys), .anyFree(anyFree),
    .curVec(curVec), .comVec(comVec)
  );
endmodule

// File: rtl/camRenameChk.sv
module camRenameChk #(
  parameter int NUM_ENTRIES = 64,
  parameter int ARCH_BITS   = 5,
  parameter int PHYS_BITS   = 6
) (
  input logic                   clk,
  input logic                   rstN,
  input logic                   renValid,
  input logic                   renStall,
  input logic [PHYS_BITS-1:0]   renPhys,
  input logic                   commitValid,
  input logic                   flush,
  input logic                   lookupHit,
  input logic [NUM_ENTRIES-1:0] curVec,
  input logic [NUM_ENTRIES-1:0] comVec
);
  localparam int NUM_ARCH = 1 << ARCH_BITS;

  // R2
  every_reg_mapped_chk: assert property (@(posedge clk) disable iff (!rstN)
    $countones(curVec) == NUM_ARCH && lookupHit);

  // R5
  one_committed_each_chk: assert property (@(posedge clk) disable iff (!rstN)
    $countones(comVec) == NUM_ARCH);

  // R3
  alloc_becomes_current_chk: assert property (@(posedge clk) disable iff (!rstN)
    (renValid && !renStall && !flush) |=> curVec[$past(renPhys)] && !comVec[$past(renPhys)]);

  // R6
  flush_restores_chk: assert property (@(posedge clk) disable iff (!rstN)
    (flush && !commitValid) |=> curVec == $past(comVec));

  // R7
  stall_freezes_chk: assert property (@(posedge clk) disable iff (!rstN)
    (renStall && !flush && !commitValid) |=> $stable(curVec) && $stable(comVec));

  // R7
  stall_needs_request_chk: assert property (@(posedge clk) disable iff (!rstN)
    renStall |-> renValid);
endmodule

bind camRenameMap camRenameChk #(
  .NUM_ENTRIES(NUM_ENTRIES), .ARCH_BITS(ARCH_BITS), .PHYS_BITS(PHYS_BITS)
) uChk (
  .clk(clk), .rstN(rstN), .renValid(renValid), .renStall(renStall),
  .renPhys(renPhys), .commitValid(commitValid), .flush(flush),
  .lookupHit(lookupHit), .curVec(curVec), .comVec(comVec)
);

// File: tb/sim_camRenameMap.sv
module sim_camRenameMap;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [4:0] lookupArch = '0;
  logic [5:0] lookupPhys;
  logic       lookupHit;
  logic       renValid = 1'b0;
  logic [4:0] renArch = '0;
  logic [5:0] renPhys;
  logic       renStall;
  logic       commitValid = 1'b0;
  logic [5:0] commitPhys = '0;
  logic       flush = 1'b0;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  camRenameMap u0 (
    .clk(clk), .rstN(rstN), .lookupArch(lookupArch), .lookupPhys(lookupPhys),
    .lookupHit(lookupHit), .renValid(renValid), .renArch(renArch),
    .renPhys(renPhys), .renStall(renStall), .commitValid(commitValid),
    .commitPhys(commitPhys), .flush(flush)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic checkMap(input string req, input int arch, input int exp);
    lookupArch = 5'(arch);
    #1;
    check(req, lookupPhys, exp);
    check(req, lookupHit, 1);
  endtask

  // Rename one register, checking the allocation shown before the edge.
  task automatic rename(input string req, input int arch, input int exp);
    @(negedge clk);
    renValid = 1'b1;
    renArch  = 5'(arch);
    #1;
    check(req, renPhys, exp);
    check(req, renStall, 0);
    @(negedge clk);
    renValid = 1'b0;
  endtask

  task automatic testReset();
    for (int i = 0; i < 32; i += 7) checkMap("R1", i, i);
    checkMap("R1", 31, 31);
    renValid = 1'b1; renArch = 5'd0; #1;
    check("R1", renPhys, 32);
    renValid = 1'b0;
  endtask

  task automatic testRenameCommit();
    rename("R3", 5, 32);
    checkMap("R3", 5, 32);
    checkMap("R4", 6, 6);
    rename("R4", 9, 33);
    checkMap("R4", 9, 33);
    checkMap("R2", 5, 32);
    @(negedge clk); commitValid = 1'b1; commitPhys = 6'd32;
    @(negedge clk); commitValid = 1'b0;
    rename("R5", 10, 5);
    checkMap("R5", 10, 5);
  endtask

  task automatic testFlush();
    @(negedge clk); flush = 1'b1;
    @(negedge clk); flush = 1'b0;
    checkMap("R6", 10, 10);
    checkMap("R6", 5, 32);
    checkMap("R6", 9, 9);
    rename("R6", 1, 5);
  endtask

  task automatic testCommitExclusion();
    rename("R10", 3, 33);
    rename("R10", 3, 34);
    @(negedge clk);
    commitValid = 1'b1; commitPhys = 6'd33;
    renValid = 1'b1; renArch = 5'd4;
    #1;
    check("R10", renPhys, 35);
    @(negedge clk);
    commitValid = 1'b0; renValid = 1'b0;
    checkMap("R10", 4, 35);
    checkMap("R10", 3, 34);
    @(negedge clk); flush = 1'b1;
    @(negedge clk); flush = 1'b0;
    checkMap("R6", 3, 33);
    checkMap("R6", 1, 1);
  endtask

  task automatic testCommitOnFlush();
    rename("R9", 7, 3);
    @(negedge clk);
    flush = 1'b1; commitValid = 1'b1; commitPhys = 6'd3;
    renValid = 1'b1; renArch = 5'd8;
    @(negedge clk);
    flush = 1'b0; commitValid = 1'b0; renValid = 1'b0;
    checkMap("R9", 7, 3);
    checkMap("R8", 8, 8);
  endtask

  task automatic testFull();
    for (int k = 0; k < 32; k++)
      rename("R7", k, (k == 0) ? 5 : (k == 1) ? 7 : 32 + k);
    checkMap("R7", 31, 63);
    @(negedge clk);
    renValid = 1'b1; renArch = 5'd0;
    #1;
    check("R7", renStall, 1);
    @(negedge clk);
    renValid = 1'b0;
    checkMap("R7", 0, 5);
    checkMap("R7", 2, 34);
    @(negedge clk); flush = 1'b1;
    @(negedge clk); flush = 1'b0;
    checkMap("R6", 0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testRenameCommit();
    testFlush();
    testCommitExclusion();
    testCommitOnFlush();
    testFull();
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      done = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule